// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a 12-bit sampling converter. When the host raises a start request, the controller pulls the active-low chip select down, which takes the analog sample, and then produces a serial clock divided down from the system clock. While chip select stays low it shifts in a dual-order frame. The frame carries a slot with no data, then a zero marker bit, then the result with the most significant bit first, and then an echo of the result with the least significant bit first. The echo leaves out bit 0, because both orders share that bit.

After the last rising edge of the frame and the falling edge that follows it, the controller raises chip select. In the same cycle it presents the assembled code together with a one-cycle valid pulse and an error flag. The error flag reports a nonzero marker bit or any difference between the echo and the first copy. Chip select then stays high for a minimum gap before another frame can begin.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and valid, busy and error are all low.
- R2: A start request taken while idle lowers chip select in the next cycle. A start request made while a frame or its gap is in progress is ignored, so it produces no extra frame.
- R3: The serial clock idles low. Its first rising edge comes SCLK_HALF system cycles after chip select falls, and later rising edges come every 2*SCLK_HALF cycles.
- R4: Each frame contains exactly 2*DATA_W+2 rising serial clock edges (26 for 12 bits). Chip select rises at the falling edge that follows the last of them.
- R5: Data is sampled on rising edges. The bits taken at rising edges 4 through DATA_W+3 form the code, most significant bit first, and code_o shows exactly this descending copy.
- R6: valid_o is a single-cycle pulse. It is asserted in the same cycle that chip select returns high, and code_o and err_o are updated with it.
- R7: err_o is set when the bits taken at rising edges DATA_W+4 through 2*DATA_W+2, which should be bits 1 through DATA_W-1 in ascending order, differ from the matching bits of the descending copy.
- R8: err_o is set when the marker bit sampled at rising edge 3 is 1.
- R9: The value on the data line at rising edges 1 and 2 has no effect on code_o or err_o.
- R10: Between frames, chip select stays high for at least CS_GAP system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to read one result |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Divided serial clock to the converter |
| busy_o | output | 1 | High from the start of a frame to the end of its gap |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| code_o | output | DATA_W | Result code taken from the descending copy |
| err_o | output | 1 | Marker bit nonzero or echo mismatch |

## Verification
A good converter never disagrees with itself, so the mismatch and marker checks are the hardest paths to reach. The bench's converter model takes per-frame fault settings. These can flip one chosen bit of the ascending echo, force the marker bit to one, or drive either level during the high-impedance slot. Each setting is paired with an expected result that the scoreboard compares. The minimum gap is reached by holding the start request high across two frames, which forces back-to-back reads with no host delay.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } rd_state_e;

   // start edge + high-impedance slot + marker + descending word + echo
   function automatic int frame_rises(input int w);
      return 2 * w + 2;
   endfunction

endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
   parameter int SCLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = $clog2(SCLK_HALF + 1);

   logic [CW-1:0] cnt_q;
   logic          sclk_q;
   logic          tick;

   assign tick   = en_i && (cnt_q == CW'(SCLK_HALF - 1));
   assign rise_o = tick & ~sclk_q;
   assign fall_o = tick & sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end

   // R3
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !sclk_o);

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
   parameter int DATA_W     = 12,
   parameter bit ECHO_CHECK = 1'b1,
   parameter int IW         = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              rise_i,
   input  logic [IW-1:0]     idx_i,
   input  logic              sd_i,
   output logic [DATA_W-1:0] code_o,
   output logic              err_o
);

   localparam int MARK_IX = 3;
   localparam int DESC_LO = 4;
   localparam int DESC_HI = DATA_W + 3;
   localparam int ASC_LO  = DATA_W + 4;
   localparam int ASC_HI  = 2 * DATA_W + 2;

   logic [DATA_W-1:0] desc_q;
   logic [DATA_W-2:0] asc_q;
   logic              mark_q;
   logic              echo_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_q <= '0;
         asc_q  <= '0;
         mark_q <= 1'b0;
      end else if (clear_i) begin
         desc_q <= '0;
         asc_q  <= '0;
         mark_q <= 1'b0;
      end else if (rise_i) begin
         if (idx_i == IW'(MARK_IX)) begin
            mark_q <= sd_i;
         end else if (idx_i >= IW'(DESC_LO) && idx_i <= IW'(DESC_HI)) begin
            desc_q <= {desc_q[DATA_W-2:0], sd_i};
         end else if (idx_i >= IW'(ASC_LO) && idx_i <= IW'(ASC_HI)) begin
            asc_q  <= {sd_i, asc_q[DATA_W-2:1]};
         end
      end
   end

   generate
      if (ECHO_CHECK) begin : g_echo
         assign echo_bad = (asc_q != desc_q[DATA_W-1:1]);
      end else begin : g_no_echo
         assign echo_bad = 1'b0;
      end
   endgenerate

   assign code_o = desc_q;
   assign err_o  = mark_q | echo_bad;

   // R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |-> (idx_i != '0) && (idx_i <= IW'(ASC_HI)));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adcrd_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int SCLK_HALF  = 2,
   parameter int CS_GAP     = 4,
   parameter bit ECHO_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sdata_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              busy_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] code_o,
   output logic              err_o
);

   localparam int FR = frame_rises(DATA_W);
   localparam int RW = $clog2(FR + 1);
   localparam int GW = $clog2(CS_GAP + 1);

   generate
      if (DATA_W < 3) begin : g_w_bad
         $error("adc_frame_reader: DATA_W must be at least 3");
      end
      if (SCLK_HALF < 1) begin : g_half_bad
         $error("adc_frame_reader: SCLK_HALF must be at least 1");
      end
      if (CS_GAP < 1) begin : g_gap_bad
         $error("adc_frame_reader: CS_GAP must be at least 1");
      end
   endgenerate

   rd_state_e         st_q;
   logic [RW-1:0]     rise_cnt_q;
   logic [GW-1:0]     gap_cnt_q;
   logic [GW-1:0]     hi_cnt_q;
   logic              rise_p, fall_p;
   logic [DATA_W-1:0] cap_code;
   logic              cap_err;
   logic              valid_q, err_q;
   logic [DATA_W-1:0] code_q;

   adcrd_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (st_q == ST_RUN),
      .sclk_o (sclk_o),
      .rise_o (rise_p),
      .fall_o (fall_p)
   );

   adcrd_capture #(.DATA_W(DATA_W), .ECHO_CHECK(ECHO_CHECK), .IW(RW)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (st_q == ST_IDLE),
      .rise_i  (rise_p),
      .idx_i   (rise_cnt_q + RW'(1)),
      .sd_i    (sdata_i),
      .code_o  (cap_code),
      .err_o   (cap_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         rise_cnt_q <= '0;
         gap_cnt_q  <= '0;
         valid_q    <= 1'b0;
         code_q     <= '0;
         err_q      <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               rise_cnt_q <= '0;
               if (start_i) st_q <= ST_RUN;
            end
            ST_RUN: begin
               if (rise_p) rise_cnt_q <= rise_cnt_q + RW'(1);
               if (fall_p && rise_cnt_q == RW'(FR)) begin
                  st_q      <= ST_GAP;
                  gap_cnt_q <= '0;
                  valid_q   <= 1'b1;
                  code_q    <= cap_code;
                  err_q     <= cap_err;
               end
            end
            ST_GAP: begin
               if (gap_cnt_q == GW'(CS_GAP - 1)) st_q <= ST_IDLE;
               else gap_cnt_q <= gap_cnt_q + GW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // cycles with chip select high, saturating; feeds the gap assertion only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hi_cnt_q <= GW'(CS_GAP);
      else if (!cs_n_o)                  hi_cnt_q <= '0;
      else if (hi_cnt_q != GW'(CS_GAP))  hi_cnt_q <= hi_cnt_q + GW'(1);
   end

   assign cs_n_o  = (st_q != ST_RUN);
   assign busy_o  = (st_q != ST_IDLE);
   assign valid_o = valid_q;
   assign code_o  = code_q;
   assign err_o   = err_q;

   // R3
   sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

   // R4
   rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p |-> rise_cnt_q < RW'(FR));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6
   valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> valid_o);

   // R2
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> $past(start_i));

   // R10
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> hi_cnt_q >= GW'(CS_GAP));

endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;

   localparam int CLK_PERIOD = 10;
   localparam int W    = 12;
   localparam int HALF = 2;
   localparam int GAP  = 3;
   localparam int FR   = 2 * W + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sd = 1'b1;
   logic cs_n, sclk, busy, valid, err;
   logic [W-1:0] code;

   adc_frame_reader #(.DATA_W(W), .SCLK_HALF(HALF), .CS_GAP(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(sd),
      .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
      .code_o(code), .err_o(err));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit fin = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!fin) begin
         fin = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // converter model: item = {zval, bad_mark, flip[3:0], code[11:0]}
   logic [17:0] mq[$];
   logic [12:0] sq[$];   // expected {err, code}
   logic [W-1:0] m_code;
   logic m_z, m_bm;
   logic [3:0] m_flip;
   int fcnt;

   always @(negedge cs_n) begin
      if (mq.size() > 0) {m_z, m_bm, m_flip, m_code} = mq.pop_front();
      else {m_z, m_bm, m_flip, m_code} = '0;
      fcnt = 0;
      sd = m_z;
   end

   always @(posedge cs_n) sd = 1'b1;

   always @(negedge sclk) begin
      if (!cs_n) begin
         fcnt++;
         if (fcnt == 1) sd = m_z;
         else if (fcnt == 2) sd = m_bm;
         else if (fcnt <= W + 2) sd = m_code[W + 2 - fcnt];
         else if (fcnt <= 2 * W + 1) sd = m_code[fcnt - W - 2] ^ (int'(m_flip) == fcnt - W - 2);
         else sd = 1'b0;
      end
   end

   // monitor / scoreboard
   int cyc = 0, cs_fall_cyc = 0, cs_rise_cyc = 0, last_rise = 0, rises = 0;
   int vcount = 0, nfalls = 0;
   bit had_frame = 0, prev_cs = 1, prev_sclk = 0, prev_valid = 0;

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         cyc++;
         if (!cs_n && prev_cs) begin
            if (had_frame) chk(cyc - cs_rise_cyc >= GAP, "R10 gap", cyc - cs_rise_cyc, GAP);
            cs_fall_cyc = cyc;
            rises = 0;
            nfalls++;
         end
         if (sclk && !prev_sclk) begin
            if (rises == 0) chk(cyc - cs_fall_cyc == HALF, "R3 first rise", cyc - cs_fall_cyc, HALF);
            else chk(cyc - last_rise == 2 * HALF, "R3 period", cyc - last_rise, 2 * HALF);
            last_rise = cyc;
            rises++;
         end
         if (cs_n && !prev_cs) begin
            chk(rises == FR, "R4 rises", rises, FR);
            chk(valid, "R6 valid at cs rise", valid, 1);
            cs_rise_cyc = cyc;
            had_frame = 1;
         end
         if (valid) begin
            vcount++;
            chk(!prev_valid, "R6 pulse width", 2, 1);
            if (sq.size() == 0) chk(0, "R2 spurious result", 1, 0);
            else begin
               logic [12:0] e;
               e = sq.pop_front();
               chk(code == e[11:0], "R5 code", code, e[11:0]);
               chk(err == e[12], "R7 R8 R9 err", err, e[12]);
            end
         end
         prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
      end
   end

   task automatic push_item(input logic [W-1:0] c, input logic z, input logic bm, input logic [3:0] flip);
      mq.push_back({z, bm, flip, c});
      sq.push_back({(bm | (flip != 0)), c});
   endtask

   int frames = 0;

   task automatic run_frame(input logic [W-1:0] c, input logic z, input logic bm, input logic [3:0] flip);
      push_item(c, z, bm, flip);
      frames++;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
      chk(sclk == 1'b0, "R1 sclk", sclk, 0);
      chk(valid == 1'b0 && busy == 1'b0 && err == 1'b0, "R1 flags", {valid, busy, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2);

      // R5 clean frames with corner codes
      run_frame(12'h000, 1'b1, 1'b0, 4'd0);
      run_frame(12'hFFF, 1'b1, 1'b0, 4'd0);
      run_frame(12'h800, 1'b1, 1'b0, 4'd0);
      run_frame(12'h001, 1'b1, 1'b0, 4'd0);
      for (int i = 0; i < 4; i++) run_frame(W'($urandom), 1'b1, 1'b0, 4'd0);

      // R7 echo mismatch at low, high and middle bit
      run_frame(12'hA5C, 1'b1, 1'b0, 4'd1);
      run_frame(12'h3C3, 1'b1, 1'b0, 4'd11);
      run_frame(12'h0F0, 1'b1, 1'b0, 4'd5);

      // R8 bad marker bit, echo intact
      run_frame(12'h555, 1'b1, 1'b1, 4'd0);

      // R9 high-impedance slot driven either way
      run_frame(12'h2B7, 1'b0, 1'b0, 4'd0);
      run_frame(12'hD48, 1'b1, 1'b0, 4'd0);

      // R2 start pulses while busy are ignored
      push_item(12'h6E1, 1'b1, 1'b0, 4'd0);
      frames++;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(vcount == frames, "R2 one result per accepted start", vcount, frames);
      chk(busy == 1'b0 && cs_n == 1'b1, "R2 no extra frame", {busy, cs_n}, 1);

      // R10 back-to-back frames with start held high
      push_item(12'h9A3, 1'b1, 1'b0, 4'd0);
      push_item(12'h17E, 1'b0, 1'b0, 4'd0);
      frames += 2;
      begin
         int base;
         base = nfalls;
         @(negedge clk) start = 1'b1;
         while (nfalls < base + 2) @(negedge clk);
         start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (5) @(negedge clk);

      chk(vcount == frames, "R6 result count", vcount, frames);
      chk(sq.size() == 0, "R5 scoreboard drained", sq.size(), 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         checks++;
         errors++;
         $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

endmodule